// File: doc/BRIEF.md
# CDF Table Binary-Search Sampler

This block draws random samples whose distribution follows any shape the host chooses. The host writes a cumulative distribution table into the block. Each entry is a 32-bit unsigned word, and the entries must never decrease with rising index. Each time a sample is requested, a 32-bit linear-feedback shift register (LFSR) supplies a uniform key. A state machine then runs a binary search over the table, one comparison per clock. It reports the smallest index whose entry is at least the key. That index is the sample.

When the table is small, a parameter switches the block into a direct-lookup variant. In that variant the top key bits address the table directly, and the low bits of the addressed word are returned, so the host stores an inverse distribution instead.

The control state machine has four states:
- `ST_IDLE` is the only state in which the block is ready.
- An accepted start moves it to `ST_SEARCH` in the binary variant, or to `ST_LOOKUP` in the direct variant.
- `ST_SEARCH` stays put until its last comparison, then moves to `ST_FINISH`.
- `ST_LOOKUP` always moves to `ST_FINISH` after one cycle.
- `ST_FINISH` always returns to `ST_IDLE` after one cycle.

Top module: `cdf_sampler`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `ready` is 1, `done` is 0 and `sample_idx` is 0. The LFSR holds the parameter `SEED` (default 1).
- R2: The LFSR shifts toward the MSB. Its new bit 0 is the XOR of bits 31, 21, 1 and 0. The key used by a sample is the LFSR value at the clock edge that accepts the start. The LFSR advances exactly once on that edge and never on any other edge.
- R3: A start is accepted only on an edge where `ready` is 1. `ready` is 0 from the next cycle until the `done` cycle has ended. A start raised while the block is busy has no effect.
- R4: In binary mode, `done` is 1 for exactly one cycle, beginning log2(`DEPTH`) rising edges after the accepting edge (7 edges for 128 entries). `ready` returns on the following edge.
- R5: In binary mode, the result is the smallest index i for which table[i] ≥ key, compared as unsigned numbers. This includes an entry exactly equal to the key, and index 0 when entry 0 already covers the key.
- R6: In binary mode, a key larger than every entry yields index `DEPTH`-1 (127).
- R7: `sample_idx` changes only on the edge that starts a `done` cycle, and it holds its value between results.
- R8: When `wr_en` is 1 on an edge where `ready` is 1, `wr_data` is stored at `wr_addr`. When `wr_en` is 1 on an edge where `ready` is 0, the write is dropped and the table is unchanged.
- R9: With `DIRECT_LOOKUP`=1, the result is the low log2(`DEPTH`) bits of table[key[31 : 32-log2(`DEPTH`)]]. `done` is 1 for one cycle, beginning one edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe (honoured only while ready) |
| wr_addr | input | log2(DEPTH) | Table write index |
| wr_data | input | KEY_W | Table entry value |
| start | input | 1 | Request one sample |
| ready | output | 1 | Idle and able to accept a start |
| sample_idx | output | log2(DEPTH) | Most recent sample index |
| done | output | 1 | One-cycle pulse when `sample_idx` is new |

## Verification
The embedded assertions check properties that hold on every cycle:
- `ready` and `done` are never both high.
- The block leaves the ready state right after accepting a start.
- `done` is a single-cycle pulse, and `sample_idx` moves only into a `done` cycle.
- The LFSR stays still and non-zero except on an accepted start.
- The search bounds stay ordered and have converged when the search ends.

The bench scenarios are needed for the rest:
- that each result matches a linear scan over the current table for the exact LFSR key sequence;
- the latency counts;
- exact-equality and beyond-the-last-entry keys;
- the direct-lookup variant;
- that a start or a table write issued mid-search leaves both the key sequence and the table untouched.

// File: rtl/cdfs_pkg.sv
package cdfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_LOOKUP,
        ST_FINISH
    } cdfs_state_e;

endpackage

// File: rtl/cdfs_lfsr.sv
module cdfs_lfsr #(
    parameter int              W        = 32,
    parameter logic [W-1:0]    SEED     = W'(1),
    parameter logic [W-1:0]    TAP_MASK = W'(32'h8020_0003)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;
    logic         feedback;

    assign feedback = ^(state_q & TAP_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= SEED;
        else if (step) state_q <= {state_q[W-2:0], feedback};
    end

    assign value = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R2

endmodule

// File: rtl/cdfs_table.sv
module cdfs_table #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cdfs_ctrl.sv
module cdfs_ctrl
    import cdfs_pkg::*;
#(
    parameter int KEY_W  = 32,
    parameter int DEPTH  = 128,
    parameter bit DIRECT = 1'b0,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key_in,
    input  logic [KEY_W-1:0] rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             key_take,
    output logic             ready,
    output logic             done,
    output logic [IDX_W-1:0] sample_idx
);

    localparam int               CNT_W = $clog2(IDX_W + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(IDX_W - 1);

    cdfs_state_e      state_q, state_d;
    logic [KEY_W-1:0] key_q;
    logic [IDX_W-1:0] lo_q, hi_q, lo_nx, hi_nx, mid, res_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W:0]   span_sum;

    // Midpoint of the live range, rounded down.
    assign span_sum = {1'b0, lo_q} + {1'b0, hi_q};
    assign mid      = span_sum[IDX_W:1];

    // One compare step: keep the half that still holds the answer.
    always_comb begin
        lo_nx = lo_q;
        hi_nx = hi_q;
        if (rd_data >= key_q) hi_nx = mid;
        else                  lo_nx = mid + IDX_W'(1);
    end

    generate
        if (DIRECT) begin : g_direct_addr
            assign rd_addr = key_q[KEY_W-1 -: IDX_W];
        end else begin : g_search_addr
            assign rd_addr = mid;
        end
    endgenerate

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = DIRECT ? ST_LOOKUP : ST_SEARCH;
            ST_SEARCH: if (cnt_q == LAST) state_d = ST_FINISH;
            ST_LOOKUP: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            cnt_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        key_q <= key_in;
                        lo_q  <= '0;
                        hi_q  <= IDX_W'(DEPTH - 1);
                        cnt_q <= '0;
                    end
                end
                ST_SEARCH: begin
                    lo_q  <= lo_nx;
                    hi_q  <= hi_nx;
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST) res_q <= lo_nx;
                end
                ST_LOOKUP: res_q <= rd_data[IDX_W-1:0];
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ready      = (state_q == ST_IDLE);
        done       = (state_q == ST_FINISH);
        key_take   = (state_q == ST_IDLE) && start;
        sample_idx = res_q;
    end

    AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_idx) |-> done); // R7
    AST_BOUNDS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (lo_q <= hi_q)); // R5
    AST_SEARCH_CONVERGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && cnt_q == LAST) |-> (lo_nx == hi_nx)); // R6

endmodule

// File: rtl/cdf_sampler.sv
module cdf_sampler #(
    parameter int               KEY_W         = 32,
    parameter int               DEPTH         = 128,
    parameter bit               DIRECT_LOOKUP = 1'b0,
    parameter logic [KEY_W-1:0] SEED          = KEY_W'(1),
    parameter logic [KEY_W-1:0] TAP_MASK      = KEY_W'(32'h8020_0003),
    localparam int              IDX_W         = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             start,
    output logic             ready,
    output logic [IDX_W-1:0] sample_idx,
    output logic             done
);

    logic [KEY_W-1:0] lfsr_q;
    logic [KEY_W-1:0] rd_data;
    logic [IDX_W-1:0] rd_addr;
    logic             key_take;
    logic             tbl_we;

    assign tbl_we = wr_en && ready;

    cdfs_lfsr #(.W(KEY_W), .SEED(SEED), .TAP_MASK(TAP_MASK)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (key_take),
        .value (lfsr_q)
    );

    cdfs_table #(.DEPTH(DEPTH), .W(KEY_W)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    cdfs_ctrl #(.KEY_W(KEY_W), .DEPTH(DEPTH), .DIRECT(DIRECT_LOOKUP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .key_in     (lfsr_q),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .key_take   (key_take),
        .ready      (ready),
        .done       (done),
        .sample_idx (sample_idx)
    );

    AST_ACCEPT_LEAVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready); // R3
    AST_LFSR_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && ready) |=> $stable(lfsr_q)); // R2

endmodule

// File: tb/test_cdf_sampler.sv
module test_cdf_sampler;

    localparam logic [31:0] D_SEED = 32'hACE1_2345;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, start = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ready, done;
    logic [6:0]  sample_idx;

    logic        d_wr_en = 1'b0, d_start = 1'b0;
    logic [3:0]  d_wr_addr = '0;
    logic [31:0] d_wr_data = '0;
    logic        d_ready, d_done;
    logic [3:0]  d_idx;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] tbl  [128];
    logic [31:0] dtbl [16];
    logic [31:0] lfsr_m  = 32'h1;
    logic [31:0] dlfsr_m = D_SEED;

    always #5 clk = ~clk;

    cdf_sampler i_cdf_sampler (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .ready(ready),
        .sample_idx(sample_idx), .done(done)
    );

    cdf_sampler #(.DEPTH(16), .DIRECT_LOOKUP(1'b1), .SEED(D_SEED)) i_direct (
        .clk(clk), .rst_n(rst_n), .wr_en(d_wr_en), .wr_addr(d_wr_addr),
        .wr_data(d_wr_data), .start(d_start), .ready(d_ready),
        .sample_idx(d_idx), .done(d_done)
    );

    function automatic logic [31:0] lfsr_nx(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic int ref_scan(input logic [31:0] key);
        for (int i = 0; i < 128; i++)
            if (tbl[i] >= key) return i;
        return 127;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic write_word(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        tbl[a] = d;
    endtask

    task automatic load_random(input int maxstep);
        logic [31:0] acc = '0;
        for (int i = 0; i < 128; i++) begin
            acc = acc + $urandom_range(0, maxstep);
            write_word(i, acc);
        end
    endtask

    task automatic load_const(input int split, input logic [31:0] below, input logic [31:0] above);
        for (int i = 0; i < 128; i++)
            write_word(i, (i < split) ? below : above);
    endtask

    // One sample on the main instance; optional mid-search start and write.
    task automatic run_main(input bit inject, output int lat, output int res, output bit busy_ok);
        lat = 0; busy_ok = 1'b1;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (inject && lat == 3) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 7'd0; wr_data = 32'hFFFF_FFFF;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            if (done || lat > 100) break;
            if (ready) busy_ok = 1'b0;
            @(posedge clk); lat++;
        end
        start = 1'b0; wr_en = 1'b0;
        res = sample_idx;
    endtask

    task automatic sample_check(input bit inject, input string tag);
        int lat, res, exp;
        bit busy_ok;
        exp = ref_scan(lfsr_m);
        run_main(inject, lat, res, busy_ok);
        check(res == exp, {tag, " R2 R5 result"}, res, exp);
        check(lat == 7, "R4 latency", lat, 7);
        check(busy_ok, "R3 ready low while busy", 0, 1);
        lfsr_m = lfsr_nx(lfsr_m);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin : main
        int lat, res, exp;
        bit busy_ok;
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R1 ready in reset", ready, 1);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 after release", {ready, done}, 2);
        check(sample_idx == 7'd0, "R1 sample_idx", sample_idx, 0);

        // R8: tables loaded while idle take effect; random CDFs of varied slope.
        load_random(32'h01FF_FFFF);
        for (int n = 0; n < 60; n++) begin
            sample_check(1'b0, "R8 rand-wide");
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        load_random(1000);
        for (int n = 0; n < 40; n++) sample_check(1'b0, "rand-steep");
        load_random(32'h00FF_FFFF);
        for (int n = 0; n < 40; n++) sample_check(1'b0, "rand-mid");

        // R6: every entry below every nonzero key.
        load_const(128, 32'd0, 32'd0);
        exp = 127;
        run_main(1'b0, lat, res, busy_ok);
        check(res == exp, "R6 key beyond all entries", res, exp);
        lfsr_m = lfsr_nx(lfsr_m);

        // R5: exact equality at index 50, then at index 0.
        load_const(50, lfsr_m - 32'd1, lfsr_m);
        run_main(1'b0, lat, res, busy_ok);
        check(res == 50, "R5 equal entry", res, 50);
        lfsr_m = lfsr_nx(lfsr_m);
        load_const(0, 32'd0, lfsr_m);
        run_main(1'b0, lat, res, busy_ok);
        check(res == 0, "R5 entry zero covers key", res, 0);
        lfsr_m = lfsr_nx(lfsr_m);

        // R3 R8: start and write during search are dropped.
        load_random(32'h01FF_FFFF);
        sample_check(1'b1, "R3 R8 inject");
        for (int n = 0; n < 4; n++) sample_check(1'b0, "R3 R8 after inject");

        // R7: result holds while idle.
        res = sample_idx;
        repeat (5) @(negedge clk);
        check(sample_idx == 7'(res) && !done, "R7 hold", sample_idx, res);

        // R9: direct lookup instance.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            d_wr_en = 1'b1; d_wr_addr = 4'(i); d_wr_data = 32'((i * 7 + 3) % 16) | 32'hA5A5_0000;
            dtbl[i] = 32'((i * 7 + 3) % 16) | 32'hA5A5_0000;
        end
        @(negedge clk); d_wr_en = 1'b0;
        for (int n = 0; n < 30; n++) begin
            int dlat;
            logic [3:0] dexp;
            dexp = dtbl[dlfsr_m[31:28]][3:0];
            dlat = 0;
            @(negedge clk); d_start = 1'b1;
            @(posedge clk);
            forever begin
                @(negedge clk); d_start = 1'b0;
                if (d_done || dlat > 100) break;
                @(posedge clk); dlat++;
            end
            check(d_idx == dexp, "R9 R2 direct result", d_idx, dexp);
            check(dlat == 1, "R9 direct latency", dlat, 1);
            dlfsr_m = lfsr_nx(dlfsr_m);
        end

        finish_up();
    end

endmodule